// File: doc/BRIEF.md
# Minimum-Magnitude Channel Combiner

This block is the last stage of a split-spectrum flaw detector. Several narrowband channels arrive together, one sample from each per cycle, already normalized and time-aligned on one parallel bus with a single valid strobe. For every sample index, the block picks the channel whose absolute value is smallest. It emits that channel's value with its sign unchanged, so a later classifier still sees the echo polarity. The result is written into an internal dual-port result memory, and a processor reads it back on the second port.

A record begins with a start strobe, which captures the sample count. Accepted samples take consecutive memory addresses starting at zero. When the last sample of the record is written, a one-cycle done pulse is raised. The channel count is a parameter, with 4, 8 and 12 as the supported configurations. The comparison runs as a registered binary tree. When the channel count is not a power of two, the tree is padded with entries that can never be selected.

Top module: `minmag_combiner`

## Requirements
- R1: For each accepted sample, `wr_data_o` holds the channel value whose two's-complement absolute value is smallest, with that channel's own sign.
- R2: When several channels share the smallest magnitude, the channel with the lowest index (channel c at bits c*DATA_W upward) is chosen.
- R3: The most negative input (for 16 bits, 16'h8000) has magnitude 2^(DATA_W-1). It therefore loses to the largest positive value, and no overflow occurs.
- R4: Each accepted sample gives exactly one write. The write appears ceil(log2(NUM_CH)) cycles after the edge that accepted the sample. Write addresses count up from 0 within a record.
- R5: `start_i` captures `cfg_len_i`, clamped to 2^ADDR_W, as the record length. Only that many valid samples are accepted, and later ones are ignored. A valid sample in the same cycle as `start_i` is not accepted.
- R6: `done_o` is high for exactly one cycle, together with the write of the record's final sample.
- R7: Cycles with `in_valid_i` low produce no write, and gaps between samples are allowed.
- R8: `rd_data_o` returns the memory word at `rd_addr_i` one cycle after the address is presented.
- R9: After reset, `wr_en_o`, `done_o` and `rd_data_o` are 0. Samples are ignored until the first `start_i`.
- R10: A length of 0 accepts no samples. A `start_i` during a record abandons it, and the new record writes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a record and captures the length |
| cfg_len_i | input | ADDR_W+1 | Record length in samples |
| in_valid_i | input | 1 | Channel bus holds a sample |
| in_data_i | input | NUM_CH*DATA_W | Signed channel samples, channel 0 in the low bits |
| wr_en_o | output | 1 | Result write strobe |
| wr_addr_o | output | ADDR_W | Result write address |
| wr_data_o | output | DATA_W | Signed selected sample |
| done_o | output | 1 | Final sample of record written |
| rd_addr_i | input | ADDR_W | Processor read address |
| rd_data_o | output | DATA_W | Processor read data, one cycle latency |

## Verification
The bench applies equal-magnitude values of opposite sign across channels. A comparator that prefers the higher index, or the negative over the positive, would store the wrong polarity. It applies the most negative code against the largest positive code; a plain negate would wrap that value to a small magnitude, and it would wrongly win. It runs records longer than their configured length, of length zero, and longer than the memory allows. An off-by-one in the counter would write one sample too many, drop the last one, or raise done at the wrong time. A restart in the middle of a record is also applied; a design that did not clear its counter would resume at a stale address. With twelve channels the tree is padded, so a badly initialized padding entry would show up as a zero result.

// File: rtl/minmag_pkg.sv
package minmag_pkg;
  typedef enum logic {REC_IDLE, REC_RUN} rec_state_e;

  function automatic int unsigned tree_depth(input int unsigned n);
    int unsigned d;
    d = 0;
    while ((1 << d) < n) d++;
    return d;
  endfunction
endpackage

// File: rtl/minmag_rec_ctrl.sv
module minmag_rec_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W:0]   cfg_len_i,
  input  logic              in_valid_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  import minmag_pkg::*;

  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

  rec_state_e      state_q;
  logic [ADDR_W:0] cnt_q, len_q, len_eff, cnt_nxt;

  assign len_eff = (cfg_len_i > DEPTH) ? DEPTH : cfg_len_i;
  assign cnt_nxt = cnt_q + (ADDR_W+1)'(1);
  assign acc_o   = (state_q == REC_RUN) && in_valid_i && !start_i;
  assign addr_o  = cnt_q[ADDR_W-1:0];
  assign last_o  = (cnt_nxt == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= REC_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (start_i) begin
      len_q   <= len_eff;
      cnt_q   <= '0;
      state_q <= (len_eff != '0) ? REC_RUN : REC_IDLE;
    end else if (acc_o) begin
      cnt_q <= cnt_nxt;
      if (last_o) state_q <= REC_IDLE;
    end
  end
endmodule

// File: rtl/minmag_stage.sv
module minmag_stage #(
  parameter int DATA_W = 16,
  parameter int N_OUT  = 1,
  parameter int TAG_W  = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [2*N_OUT*DATA_W-1:0] val_i,
  input  logic [2*N_OUT*DATA_W-1:0] mag_i,
  output logic                    vld_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [N_OUT*DATA_W-1:0] val_o,
  output logic [N_OUT*DATA_W-1:0] mag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) tag_o <= tag_i;
    end
  end

  for (genvar p = 0; p < N_OUT; p++) begin : g_pair
    logic [DATA_W-1:0] mag_l, mag_r, val_q, mag_q;
    logic              take_r;

    assign mag_l  = mag_i[2*p*DATA_W +: DATA_W];
    assign mag_r  = mag_i[(2*p+1)*DATA_W +: DATA_W];
    // strict compare keeps the lower-index channel on a tie
    assign take_r = mag_r < mag_l;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        mag_q <= '0;
      end else if (vld_i) begin
        val_q <= take_r ? val_i[(2*p+1)*DATA_W +: DATA_W] : val_i[2*p*DATA_W +: DATA_W];
        mag_q <= take_r ? mag_r : mag_l;
      end
    end

    assign val_o[p*DATA_W +: DATA_W] = val_q;
    assign mag_o[p*DATA_W +: DATA_W] = mag_q;
  end
endmodule

// File: rtl/minmag_result_ram.sv
module minmag_result_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/minmag_combiner.sv
module minmag_combiner #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W:0]          cfg_len_i,
  input  logic                     in_valid_i,
  input  logic [NUM_CH*DATA_W-1:0] in_data_i,
  output logic                     wr_en_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic                     done_o,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  import minmag_pkg::*;

  localparam int LVL   = tree_depth(NUM_CH);
  localparam int PAD   = 1 << LVL;
  localparam int TAG_W = ADDR_W + 1;

  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_last;
  logic [DATA_W-1:0] out_mag;

  minmag_rec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cfg_len_i  (cfg_len_i),
    .in_valid_i (in_valid_i),
    .acc_o      (acc),
    .addr_o     (acc_addr),
    .last_o     (acc_last)
  );

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int NN = PAD >> l;
    logic                 vld;
    logic [TAG_W-1:0]     tag;
    logic [NN*DATA_W-1:0] val;
    logic [NN*DATA_W-1:0] mag;

    if (l == 0) begin : g_leaf
      assign vld = acc;
      assign tag = {acc_last, acc_addr};
      for (genvar c = 0; c < PAD; c++) begin : g_ch
        if (c < NUM_CH) begin : g_real
          logic [DATA_W-1:0] x;
          assign x = in_data_i[c*DATA_W +: DATA_W];
          // unsigned magnitude: the most negative code maps to 2^(DATA_W-1)
          assign val[c*DATA_W +: DATA_W] = x;
          assign mag[c*DATA_W +: DATA_W] = x[DATA_W-1] ? (~x + DATA_W'(1)) : x;
        end else begin : g_pad
          assign val[c*DATA_W +: DATA_W] = '0;
          assign mag[c*DATA_W +: DATA_W] = '1;
        end
      end
    end else begin : g_node
      minmag_stage #(.DATA_W(DATA_W), .N_OUT(NN), .TAG_W(TAG_W)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (g_lvl[l-1].vld),
        .tag_i  (g_lvl[l-1].tag),
        .val_i  (g_lvl[l-1].val),
        .mag_i  (g_lvl[l-1].mag),
        .vld_o  (vld),
        .tag_o  (tag),
        .val_o  (val),
        .mag_o  (mag)
      );
    end
  end

  assign wr_en_o   = g_lvl[LVL].vld;
  assign wr_addr_o = g_lvl[LVL].tag[ADDR_W-1:0];
  assign done_o    = g_lvl[LVL].vld & g_lvl[LVL].tag[ADDR_W];
  assign wr_data_o = g_lvl[LVL].val;
  assign out_mag   = g_lvl[LVL].mag;

  minmag_result_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_o),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/minmag_combiner_chk.sv
module minmag_combiner_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              done_o,
  input logic [DATA_W-1:0] out_mag
);
  logic [ADDR_W-1:0] last_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_addr_q <= '0;
    else if (wr_en_o) last_addr_q <= wr_addr_o;
  end

  p_done_with_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_en_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != '0) |-> wr_addr_o == last_addr_q + ADDR_W'(1));

  // magnitude path and value path must agree at the tree root
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> out_mag == (wr_data_o[DATA_W-1] ? (~wr_data_o + DATA_W'(1)) : wr_data_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r9: assert (!wr_en_o && !done_o);
    end
  end
endmodule

bind minmag_combiner minmag_combiner_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .done_o    (done_o),
  .out_mag   (out_mag)
);

// File: tb/minmag_combiner_tb.sv
module minmag_combiner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;
  localparam int W   = 16;
  localparam int AW  = 10;
  localparam int LAT = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [AW:0]       cfg_len = '0;
  logic              in_valid = 1'b0;
  logic [NCH*W-1:0]  in_data = '0;
  logic              wr_en, done;
  logic [AW-1:0]     wr_addr, rd_addr = '0;
  logic [W-1:0]      wr_data, rd_data;

  int checks = 0, fails = 0, cyc = 0;
  int writes_seen = 0, dones_seen = 0;
  string cur_req = "R1";

  minmag_combiner #(.NUM_CH(NCH), .DATA_W(W), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_len_i(cfg_len),
    .in_valid_i(in_valid), .in_data_i(in_data), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input bit ok, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // reference model
  int m_run = 0, m_cnt = 0, m_len = 0;
  bit ev[LAT], el[LAT];
  int ea[LAT];
  logic [W-1:0] ed[LAT];
  logic [W-1:0] shadow[1<<AW];

  function automatic logic [W-1:0] pick(input logic [NCH*W-1:0] d);
    int best = -1, bm = 0;
    for (int c = 0; c < NCH; c++) begin
      int v, m;
      v = int'($signed(d[c*W +: W]));
      m = (v < 0) ? -v : v;
      if (best < 0 || m < bm) begin best = c; bm = m; end
    end
    return d[best*W +: W];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_len = 0;
      for (int i = 0; i < LAT; i++) begin ev[i] = 0; el[i] = 0; end
    end else begin
      if (ev[LAT-1]) shadow[ea[LAT-1]] = ed[LAT-1];
      for (int i = LAT-1; i > 0; i--) begin
        ev[i] = ev[i-1]; el[i] = el[i-1]; ea[i] = ea[i-1]; ed[i] = ed[i-1];
      end
      ev[0] = 0; el[0] = 0;
      if (start) begin
        m_len = (int'(cfg_len) > (1<<AW)) ? (1<<AW) : int'(cfg_len);
        m_cnt = 0;
        m_run = (m_len != 0);
      end else if (m_run != 0 && in_valid) begin
        ev[0] = 1; ea[0] = m_cnt; ed[0] = pick(in_data);
        el[0] = (m_cnt + 1 == m_len);
        m_cnt++;
        if (el[0]) m_run = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4", wr_en == ev[LAT-1], "wr_en", wr_en, ev[LAT-1]);
      if (ev[LAT-1]) begin
        chk("R4", int'(wr_addr) == ea[LAT-1], "wr_addr", wr_addr, ea[LAT-1]);
        chk(cur_req, wr_data == ed[LAT-1], "wr_data", wr_data, ed[LAT-1]);
      end
      chk("R6", done == (ev[LAT-1] && el[LAT-1]), "done", done, ev[LAT-1] && el[LAT-1]);
      if (wr_en) writes_seen++;
      if (done)  dones_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
    end
  end

  function automatic logic [W-1:0] rand_word();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return W'($urandom % 5) - W'(2);
      default: return W'($urandom);
    endcase
  endfunction

  task automatic begin_rec(input int len);
    @(negedge clk);
    start = 1'b1; cfg_len = (AW+1)'(len); in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [NCH*W-1:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_rand(input int n);
    for (int k = 0; k < n; k++) begin
      logic [NCH*W-1:0] d;
      for (int c = 0; c < NCH; c++) d[c*W +: W] = rand_word();
      send(d);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input int a, input logic [W-1:0] exp);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(req, rd_data == exp, "rd_data", rd_data, exp);
  endtask

  function automatic logic [NCH*W-1:0] fill(input logic [W-1:0] v);
    logic [NCH*W-1:0] d;
    for (int c = 0; c < NCH; c++) d[c*W +: W] = v;
    return d;
  endfunction

  initial begin
    int w0, d0;
    logic [NCH*W-1:0] d;
    repeat (3) @(negedge clk);
    chk("R9", !wr_en && !done && rd_data == '0, "reset outputs", {wr_en, done, rd_data}, 0);
    rst_n = 1'b1;

    // R9: samples before any start are ignored
    w0 = writes_seen;
    send_rand(3); idle(LAT + 2);
    chk("R9", writes_seen == w0, "writes before start", writes_seen - w0, 0);

    // R1 / R7: random record with gaps
    cur_req = "R1";
    w0 = writes_seen; d0 = dones_seen;
    begin_rec(40);
    for (int k = 0; k < 80 && m_run != 0; k++) begin
      if ($urandom % 3 != 0) send_rand(1); else idle(1);
    end
    idle(LAT + 2);
    chk("R7", writes_seen - w0 == 40, "writes with gaps", writes_seen - w0, 40);
    chk("R6", dones_seen - d0 == 1, "done count", dones_seen - d0, 1);

    // R2: ties go to lowest channel
    cur_req = "R2";
    begin_rec(2);
    d = fill(16'd100); d[3*W +: W] = 16'd5; d[7*W +: W] = -16'sd5; send(d);
    d = fill(16'd100); d[0*W +: W] = -16'sd7; d[5*W +: W] = 16'd7; send(d);
    idle(LAT + 2);
    read_chk("R2", 0, 16'd5);
    read_chk("R2", 1, 16'hFFF9);

    // R3: most negative code
    cur_req = "R3";
    begin_rec(2);
    d = fill(16'h8000); d[1*W +: W] = 16'h7FFF; send(d);
    send(fill(16'h8000));
    idle(LAT + 2);
    read_chk("R3", 0, 16'h7FFF);
    read_chk("R3", 1, 16'h8000);

    // R5: overrun ignored
    cur_req = "R5";
    w0 = writes_seen; d0 = dones_seen;
    begin_rec(3); send_rand(6); idle(LAT + 2);
    chk("R5", writes_seen - w0 == 3, "overrun writes", writes_seen - w0, 3);
    chk("R6", dones_seen - d0 == 1, "overrun done", dones_seen - d0, 1);

    // R10: zero length
    w0 = writes_seen;
    begin_rec(0); send_rand(4); idle(LAT + 2);
    chk("R10", writes_seen == w0, "zero-length writes", writes_seen - w0, 0);

    // R10: restart mid-record
    cur_req = "R10";
    w0 = writes_seen; d0 = dones_seen;
    begin_rec(10); send_rand(4);
    begin_rec(2); send_rand(2); idle(LAT + 2);
    chk("R10", writes_seen - w0 == 6, "restart writes", writes_seen - w0, 6);
    chk("R10", dones_seen - d0 == 1, "restart done", dones_seen - d0, 1);

    // R5: length clamp to memory depth
    cur_req = "R1";
    w0 = writes_seen; d0 = dones_seen;
    begin_rec((1 << AW) + 5); send_rand((1 << AW) + 6); idle(LAT + 2);
    chk("R5", writes_seen - w0 == (1 << AW), "clamped writes", writes_seen - w0, 1 << AW);
    chk("R6", dones_seen - d0 == 1, "clamped done", dones_seen - d0, 1);

    // R8: read port
    for (int k = 0; k < 16; k++) begin
      int a;
      a = (k * 67 + 3) % (1 << AW);
      read_chk("R8", a, shadow[a]);
    end

    summary();
  end
endmodule